// File: doc/BRIEF.md
# Presettable Binary/Decade Up-Down Counter

A four-bit synchronous counting stage that runs either as a full binary counter (0 to 15) or as a BCD decade digit (0 to 9), upward or downward. The radix and the direction are chosen at run time by two plain control pins. A load strobe forces the count to a four-bit load word at once, without waiting for the clock. An active-low count enable gates advancement. An active-low terminal flag tells a following stage that this stage is about to wrap.

Stages are chained on one shared clock. Each stage's terminal flag drives the next stage's count enable, so a chain of N stages forms a synchronous N-digit counter. The terminal flag is decoded combinationally from the visible count, the direction, the radix and the incoming enable. A carry therefore reaches the next stage within the same cycle. The block carries no data stream, so it has no valid/ready handshake. All pins are plain control and status pins.

Top module: `updn_counter`

## Requirements
- R1: While `load` is high, `cnt` equals `load_val` with no clock edge needed, and it stays at `load_val` across clock edges for as long as `load` remains high.
- R2: A load with `load_val` = 0 forces `cnt` to 0 from any prior count.
- R3: `cnt` changes on a rising edge of `clk` only when both `en_n` and `load` are low at that edge.
- R4: With `en_n` high, `cnt` holds its value across clock edges.
- R5: With `radix_bin` = 1, counting is modulo 16. Up (`dir_up` = 1) goes from 15 to 0, and down (`dir_up` = 0) goes from 0 to 15.
- R6: With `radix_bin` = 0, counting is modulo 10 on a BCD value. Up goes from 9 to 0, and down goes from 0 to 9.
- R7: `term_n` is 1 unless `en_n` is 0 and `cnt` is at the terminal value. The terminal value is 15 (binary) or 9 (decade) when counting up, and 0 when counting down. `term_n` follows `cnt`, `dir_up`, `radix_bin` and `en_n` in the same cycle.
- R8: In decade mode with a count of 10 to 15, an enabled up step gives 0 and an enabled down step gives the count minus one. `term_n` stays 1 for these values.
- R9: Two stages on one clock, with the low stage's `term_n` wired to the high stage's `en_n`, count together. They form a 0..255 counter in binary mode and a 0..99 counter in decade mode, in both directions.
- R10: `rst_n` low clears `cnt` to 0 at once, and reset takes priority over `load`.
- R11: After `load` falls, `cnt` keeps the loaded value until the next enabled rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear |
| load | input | 1 | Asynchronous load strobe, active high; also inhibits counting |
| load_val | input | 4 | Value forced onto the count while `load` is high |
| en_n | input | 1 | Active-low count enable (carry in from the previous stage) |
| radix_bin | input | 1 | 1 = modulo-16 binary, 0 = modulo-10 BCD |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| cnt | output | 4 | Current count |
| term_n | output | 1 | Active-low terminal flag (carry out to the next stage) |

## Verification
The assertions assume three things about the inputs. `load_val` is steady while `load` is high. Every load pulse spans at least one rising clock edge. The radix select does not change on the cycle a legal-range check looks back across. The stimulus changes inputs only one time unit after a clock edge, and it holds each load over a full edge. It sets radix and direction while the load is active, so every assumption holds. The sweep visits every start value in every radix/direction pair, including the illegal decade values. The chained pair is then run past its full wrap in all four modes.

// File: rtl/updn_pkg.sv
`timescale 1ns/1ps
package updn_pkg;
  localparam int DIGIT_W   = 4;
  localparam int DEC_LAST  = 9;
  typedef enum logic {RADIX_DEC = 1'b0, RADIX_BIN = 1'b1} radix_e;
endpackage

// File: rtl/updn_step.sv
`timescale 1ns/1ps
module updn_step #(
  parameter int W        = updn_pkg::DIGIT_W,
  parameter int DEC_LAST = updn_pkg::DEC_LAST
) (
  input  logic [W-1:0] cur,
  input  logic         radix_bin,
  input  logic         dir_up,
  output logic [W-1:0] nxt
);
  localparam logic [W-1:0] BIN_TOP = {W{1'b1}};
  localparam logic [W-1:0] DEC_TOP = W'(DEC_LAST);

  logic [W-1:0] top_val;
  assign top_val = (radix_bin == updn_pkg::RADIX_BIN) ? BIN_TOP : DEC_TOP;

  always_comb begin
    if (dir_up) begin
      // at or above the top value (includes illegal decade codes) wraps to 0
      if (cur >= top_val) nxt = '0;
      else                nxt = cur + W'(1);
    end else begin
      if (cur == '0) nxt = top_val;
      else           nxt = cur - W'(1);
    end
  end
endmodule

// File: rtl/updn_term.sv
`timescale 1ns/1ps
module updn_term #(
  parameter int W        = updn_pkg::DIGIT_W,
  parameter int DEC_LAST = updn_pkg::DEC_LAST
) (
  input  logic [W-1:0] cur,
  input  logic         radix_bin,
  input  logic         dir_up,
  input  logic         en_n,
  output logic         term_n
);
  localparam logic [W-1:0] BIN_TOP = {W{1'b1}};
  localparam logic [W-1:0] DEC_TOP = W'(DEC_LAST);

  logic at_top, at_bottom, at_end;
  assign at_top    = radix_bin ? (cur == BIN_TOP) : (cur == DEC_TOP);
  assign at_bottom = (cur == '0);
  assign at_end    = dir_up ? at_top : at_bottom;
  assign term_n    = ~(~en_n & at_end);
endmodule

// File: rtl/updn_cell.sv
`timescale 1ns/1ps
module updn_cell #(
  parameter int W = updn_pkg::DIGIT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         adv,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] cur
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n or posedge load) begin
    if (!rst_n)     cnt_q <= '0;
    else if (load)  cnt_q <= load_val;
    else if (adv)   cnt_q <= nxt;
  end

  // bypass so the load word shows while the strobe is high, clock or not
  assign cur = (rst_n && load) ? load_val : cnt_q;
endmodule

// File: rtl/updn_counter.sv
`timescale 1ns/1ps
module updn_counter #(
  parameter int W        = updn_pkg::DIGIT_W,
  parameter int DEC_LAST = updn_pkg::DEC_LAST
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en_n,
  input  logic         radix_bin,
  input  logic         dir_up,
  output logic [W-1:0] cnt,
  output logic         term_n
);
  logic [W-1:0] step_val;
  logic         adv;

  assign adv = ~en_n & ~load;

  updn_step #(.W(W), .DEC_LAST(DEC_LAST)) u_step (
    .cur(cnt), .radix_bin(radix_bin), .dir_up(dir_up), .nxt(step_val)
  );

  updn_cell #(.W(W)) u_cell (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
    .adv(adv), .nxt(step_val), .cur(cnt)
  );

  updn_term #(.W(W), .DEC_LAST(DEC_LAST)) u_term (
    .cur(cnt), .radix_bin(radix_bin), .dir_up(dir_up), .en_n(en_n),
    .term_n(term_n)
  );
endmodule

// File: rtl/updn_counter_chk.sv
`timescale 1ns/1ps
module updn_counter_chk #(
  parameter int W        = updn_pkg::DIGIT_W,
  parameter int DEC_LAST = updn_pkg::DEC_LAST
) (
  input logic         clk,
  input logic         rst_n,
  input logic         load,
  input logic [W-1:0] load_val,
  input logic         en_n,
  input logic         radix_bin,
  input logic         dir_up,
  input logic [W-1:0] cnt,
  input logic         term_n
);
  localparam logic [W-1:0] DTOP = W'(DEC_LAST);

  logic end_seen;
  assign end_seen = dir_up ? (cnt == (radix_bin ? {W{1'b1}} : DTOP)) : (cnt == '0);

  // R4 / R3: no enable and no load means the count holds
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_n) && !$past(load) && !load) |-> cnt == $past(cnt));

  // R5: binary up step adds one modulo 16
  a_r5_bin_up: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en_n) && !$past(load) && !load && $past(radix_bin) && $past(dir_up))
      |-> cnt == W'($past(cnt) + W'(1)));

  // R5: binary down step subtracts one modulo 16
  a_r5_bin_down: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(en_n) && !$past(load) && !load && $past(radix_bin) && !$past(dir_up))
      |-> cnt == W'($past(cnt) - W'(1)));

  // R6: a legal decade value stays legal across a step
  a_r6_dec_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!radix_bin && !$past(radix_bin) && $past(cnt) <= DTOP && !load && !$past(load))
      |-> cnt <= DTOP);

  // R11: count keeps the load word on the edge after the strobe falls
  a_r11_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(load) && !load) |-> cnt == $past(load_val));

  // R1: count equals the load word while the strobe is high
  a_r1_load_follow: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> cnt == load_val);

  // R7: terminal flag only with enable and at the terminal value
  a_r7_term_cond: assert property (@(posedge clk) disable iff (!rst_n)
    !term_n |-> (!en_n && end_seen));

  a_r7_term_fires: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && end_seen) |-> !term_n);

  // R8: illegal decade codes never raise the terminal flag
  a_r8_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!radix_bin && cnt > DTOP) |-> term_n);
endmodule

bind updn_counter updn_counter_chk #(.W(W), .DEC_LAST(DEC_LAST)) u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .en_n(en_n),
  .radix_bin(radix_bin), .dir_up(dir_up), .cnt(cnt), .term_n(term_n)
);

// File: tb/tb_updn_counter.sv
`timescale 1ns/1ps
module tb_updn_counter;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, load, en_n, radix_bin, dir_up;
  logic [3:0] load_val, cnt;
  logic       term_n;

  updn_counter dut (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .en_n(en_n),
    .radix_bin(radix_bin), .dir_up(dir_up), .cnt(cnt), .term_n(term_n)
  );

  // two chained stages on the same clock
  logic       c_load, c_en_n, c_bin, c_up;
  logic [3:0] lo_cnt, hi_cnt;
  logic       lo_term_n, hi_term_n;

  updn_counter u_lo (
    .clk(clk), .rst_n(rst_n), .load(c_load), .load_val(4'd0), .en_n(c_en_n),
    .radix_bin(c_bin), .dir_up(c_up), .cnt(lo_cnt), .term_n(lo_term_n)
  );
  updn_counter u_hi (
    .clk(clk), .rst_n(rst_n), .load(c_load), .load_val(4'd0), .en_n(lo_term_n),
    .radix_bin(c_bin), .dir_up(c_up), .cnt(hi_cnt), .term_n(hi_term_n)
  );

  int  errors = 0;
  int  checks = 0;
  bit  done   = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int f_next(int v, bit b, bit u);
    if (u) return b ? (v + 1) % 16 : ((v >= 9) ? 0 : v + 1);
    return (v == 0) ? (b ? 15 : 9) : v - 1;
  endfunction

  function automatic int f_term(int v, bit b, bit u, bit ci);
    if (ci) return 1;
    if (u)  return (v == (b ? 15 : 9)) ? 0 : 1;
    return (v == 0) ? 0 : 1;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_chain(input bit b, input bit u, input int steps);
    int modv;
    int got;
    int exp;
    modv = b ? 256 : 100;
    c_load = 1'b1; c_bin = b; c_up = u; c_en_n = 1'b0;
    tick();
    c_load = 1'b0;
    for (int k = 1; k <= steps; k++) begin
      tick();
      got = b ? (int'(hi_cnt) * 16 + int'(lo_cnt)) : (int'(hi_cnt) * 10 + int'(lo_cnt));
      exp = u ? (k % modv) : ((modv - (k % modv)) % modv);
      chk(b ? "R9 chain binary" : "R9 chain decade", got, exp);
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    int  exp;
    bit  ci;
    string tag;
    rst_n = 1'b0; load = 1'b0; load_val = 4'd0; en_n = 1'b1;
    radix_bin = 1'b1; dir_up = 1'b1;
    c_load = 1'b0; c_en_n = 1'b1; c_bin = 1'b1; c_up = 1'b1;
    tick(); tick();
    chk("R10 reset count", int'(cnt), 0);
    chk("R7 idle term", int'(term_n), 1);
    rst_n = 1'b1;
    tick();

    // exhaustive start values in every radix/direction pair
    for (int b = 0; b < 2; b++) begin
      for (int u = 0; u < 2; u++) begin
        for (int s = 0; s < 16; s++) begin
          en_n = 1'b0; radix_bin = b[0]; dir_up = u[0];
          load = 1'b1; load_val = 4'(s);
          #1;
          chk("R1 async load", int'(cnt), s);
          chk("R7 term on loaded value", int'(term_n), f_term(s, b[0], u[0], 1'b0));
          tick();
          chk("R3 load inhibits count", int'(cnt), s);
          load = 1'b0;
          exp = s;
          for (int k = 0; k < 20; k++) begin
            ci = (k % 5 == 3);
            en_n = ci;
            #1;
            chk("R7 term flag", int'(term_n), f_term(exp, b[0], u[0], ci));
            if (ci)         tag = "R4 hold";
            else if (b)     tag = "R5 binary step";
            else if (exp>9) tag = "R8 illegal decade step";
            else            tag = "R6 decade step";
            tick();
            if (!ci) exp = f_next(exp, b[0], u[0]);
            chk(tag, int'(cnt), exp);
          end
        end
      end
    end

    // R11: loaded value kept while disabled
    en_n = 1'b1; radix_bin = 1'b1; dir_up = 1'b1;
    load = 1'b1; load_val = 4'd6;
    tick();
    load = 1'b0;
    tick(); tick();
    chk("R11 value kept after load", int'(cnt), 6);

    // R2: zero load from a non-zero count
    load = 1'b1; load_val = 4'd0;
    #1;
    chk("R2 zero load", int'(cnt), 0);
    tick();
    load = 1'b0;

    // R10: asynchronous clear mid-cycle, over an active load
    load = 1'b1; load_val = 4'd11;
    #1;
    rst_n = 1'b0;
    #0.5;
    chk("R10 async clear", int'(cnt), 0);
    tick();
    load = 1'b0;
    tick();
    rst_n = 1'b1;
    tick();

    run_chain(1'b1, 1'b1, 270);
    run_chain(1'b1, 1'b0, 270);
    run_chain(1'b0, 1'b1, 120);
    run_chain(1'b0, 1'b0, 120);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule